// File: doc/BRIEF.md
# Control Channel Session Timer

This block decides when the low-rate control channel of a video link is open. While it is idle the link is in its video phase. A selectable edge on a frame-sync input starts a session: the video phase is dropped and the channel is enabled. The channel is then guarded by two timeouts that count in bit-time ticks. A start timeout waits for the host to speak. Once the host has sent its first byte, an end timeout takes over and is restarted by every later byte. The host can also end the session early by sending a configurable end-frame byte.

When the session closes, the block waits a fixed handshake interval before it hands the link back to video. Received bytes flagged with a framing error are collected during the session. They are reported by a single-cycle strobe, but only when the host closed the session with the end frame. A bypass control can withhold register-programming permission for the rest of the session, or for every later session until reset.

Top module: `ccs_session_timer`

## Requirements
- R1: With `trig_rise_i`=1 a 0-to-1 change of `fsync_i` starts a session, and with `trig_rise_i`=0 a 1-to-0 change starts one. `chan_en_o` rises and `video_en_o` falls at the first clock edge that samples the changed level. The opposite edge has no effect.
- R2: `chan_en_o` and `video_en_o` are never high together. Frame-sync edges seen while the block is not in the video phase are ignored.
- R3: When a session opens, the start timer is active (`start_tmr_o`=1, `end_tmr_o`=0) with its count at zero.
- R4: The two timers are never active together. An active timer counts `bit_tick_i` pulses and expires on the tick that brings its count to its 16-bit limit. A limit of 0 behaves like a limit of 1.
- R5: Any `rx_valid_i` byte that is not the end frame, received while the channel is open, makes the end timer the active one with its count cleared. Each such byte restarts the end timer.
- R6: When either timer expires, the channel closes at that same clock edge (`chan_en_o` falls).
- R7: A byte equal to the end-frame value, received while the channel is open, stops both timers. The channel then closes at the clock edge that samples the second `bit_tick_i` after that byte.
- R8: The end-frame value resets to 0xFF. A write through `ef_wr_i`/`ef_wdata_i` takes effect unless the data equals a device address (0x80 or 0x90). Such a write is ignored and the previous value is kept.
- R9: If a byte with `rx_err_i`=1 arrived during a session that is closed by the end frame, `err_report_o` pulses for one cycle in the cycle where `chan_en_o` first reads low. Sessions closed by a timeout never produce the pulse.
- R10: After the channel closes, `video_en_o` returns 8 cycles later (parameter `HS_CYCLES`).
- R11: `reg_wr_ok_o` is high while the channel is open, except after `bypass_en_i` has been sampled high while open. With `bypass_perm_i`=0 that block lasts until the session ends. With `bypass_perm_i`=1 it lasts until reset.
- R12: Out of reset `video_en_o`=1 and `chan_en_o`, `start_tmr_o`, `end_tmr_o`, `err_report_o` and `reg_wr_ok_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame-sync trigger input |
| trig_rise_i | input | 1 | 1: rising edge triggers, 0: falling edge triggers |
| bit_tick_i | input | 1 | One pulse per UART bit time |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Framing error flag of the received byte |
| start_lim_i | input | 16 | Start timeout limit in bit ticks |
| end_lim_i | input | 16 | End timeout limit in bit ticks |
| ef_wr_i | input | 1 | End-frame value write strobe |
| ef_wdata_i | input | 8 | End-frame value write data |
| bypass_en_i | input | 1 | Bypass request (blocks register programming) |
| bypass_perm_i | input | 1 | Makes a bypass block last until reset |
| chan_en_o | output | 1 | Control channel enabled |
| video_en_o | output | 1 | Video phase enabled |
| start_tmr_o | output | 1 | Start timer active |
| end_tmr_o | output | 1 | End timer active |
| err_report_o | output | 1 | One-cycle error report strobe |
| reg_wr_ok_o | output | 1 | Register programming permitted |

## Verification
Every output comes from a register, so each response appears at the clock edge that samples the stimulus. A trigger, a first host byte or an expiring tick is therefore visible half a cycle later, at the next falling edge. An end frame closes the channel on the edge that takes the second tick after it. Video returns eight edges after the close. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge with the same inputs, and all six outputs are compared to it at every falling edge. The directed checks sample at the falling edge that follows the stimulus task.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
   typedef enum logic [1:0] {
      ST_VIDEO   = 2'd0,
      ST_OPEN    = 2'd1,
      ST_DRAIN   = 2'd2,
      ST_HANDOFF = 2'd3
   } ccs_state_e;

   typedef enum logic [1:0] {
      TM_OFF   = 2'd0,
      TM_START = 2'd1,
      TM_END   = 2'd2
   } ccs_tphase_e;
endpackage

// File: rtl/ccs_edge_det.sv
module ccs_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic rise_sel_i,
   output logic hit_o
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_i;
   end

   assign hit_o = rise_sel_i ? (sig_i & ~sig_q) : (~sig_i & sig_q);
endmodule

// File: rtl/ccs_ef_reg.sv
module ccs_ef_reg #(
   parameter int unsigned            DW        = 8,
   parameter int unsigned            NUM_DEV   = 2,
   parameter logic [NUM_DEV*DW-1:0]  DEV_ADDRS = {8'h90, 8'h80},
   parameter logic [DW-1:0]          EF_RESET  = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] ef_o
);
   logic [NUM_DEV-1:0] clash;

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_addr
      assign clash[i] = (wdata_i == DEV_ADDRS[i*DW +: DW]);
      if (EF_RESET == DEV_ADDRS[i*DW +: DW]) begin : g_bad_reset
         $error("ccs_ef_reg: EF_RESET equals a device address");
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ef_o <= EF_RESET;
      else if (wr_i && !(|clash)) ef_o <= wdata_i;
   end
endmodule

// File: rtl/ccs_timeout.sv
module ccs_timeout
   import ccs_pkg::*;
#(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic          hold_i,
   input  logic          act_i,
   input  logic          tick_i,
   input  logic [TW-1:0] start_lim_i,
   input  logic [TW-1:0] end_lim_i,
   output logic          start_act_o,
   output logic          end_act_o,
   output logic          expire_o
);
   ccs_tphase_e   phase;
   logic [TW-1:0] cnt;
   logic [TW:0]   next_cnt;
   logic [TW:0]   lim;

   assign next_cnt = {1'b0, cnt} + 1'b1;
   assign lim      = {1'b0, (phase == TM_START) ? start_lim_i : end_lim_i};
   assign expire_o = (phase != TM_OFF) && !arm_i && !hold_i && !act_i &&
                     tick_i && (next_cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= TM_OFF;
         cnt   <= '0;
      end else if (arm_i) begin
         phase <= TM_START;
         cnt   <= '0;
      end else if (hold_i) begin
         phase <= TM_OFF;
         cnt   <= '0;
      end else if (phase != TM_OFF) begin
         if (act_i) begin
            phase <= TM_END;
            cnt   <= '0;
         end else if (expire_o) begin
            phase <= TM_OFF;
            cnt   <= '0;
         end else if (tick_i) begin
            cnt   <= next_cnt[TW-1:0];
         end
      end
   end

   assign start_act_o = (phase == TM_START);
   assign end_act_o   = (phase == TM_END);
endmodule

// File: rtl/ccs_session_timer.sv
module ccs_session_timer
   import ccs_pkg::*;
#(
   parameter int unsigned            TW         = 16,
   parameter int unsigned            DW         = 8,
   parameter int unsigned            HS_CYCLES  = 8,
   parameter int unsigned            NUM_DEV    = 2,
   parameter logic [NUM_DEV*DW-1:0]  DEV_ADDRS  = {8'h90, 8'h80},
   parameter logic [DW-1:0]          EF_RESET   = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fsync_i,
   input  logic          trig_rise_i,
   input  logic          bit_tick_i,
   input  logic          rx_valid_i,
   input  logic [DW-1:0] rx_data_i,
   input  logic          rx_err_i,
   input  logic [TW-1:0] start_lim_i,
   input  logic [TW-1:0] end_lim_i,
   input  logic          ef_wr_i,
   input  logic [DW-1:0] ef_wdata_i,
   input  logic          bypass_en_i,
   input  logic          bypass_perm_i,
   output logic          chan_en_o,
   output logic          video_en_o,
   output logic          start_tmr_o,
   output logic          end_tmr_o,
   output logic          err_report_o,
   output logic          reg_wr_ok_o
);
   localparam int unsigned HW = (HS_CYCLES > 1) ? $clog2(HS_CYCLES) : 1;
   localparam logic [HW-1:0] HS_LAST = HW'(HS_CYCLES - 1);

   if (TW < 1 || DW < 1 || HS_CYCLES < 1 || NUM_DEV < 1) begin : g_param_chk
      $error("ccs_session_timer: illegal parameter value");
   end

   ccs_state_e    state;
   logic          trig;
   logic          ef_hit;
   logic          expire;
   logic          in_open;
   logic [DW-1:0] ef_val;
   logic          drain_cnt;
   logic [HW-1:0] hs_cnt;
   logic          err_seen;
   logic          sess_lock;
   logic          perm_lock;

   assign in_open = (state == ST_OPEN);
   assign ef_hit  = in_open && rx_valid_i && (rx_data_i == ef_val);

   ccs_edge_det u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sig_i      (fsync_i),
      .rise_sel_i (trig_rise_i),
      .hit_o      (trig)
   );

   ccs_ef_reg #(
      .DW        (DW),
      .NUM_DEV   (NUM_DEV),
      .DEV_ADDRS (DEV_ADDRS),
      .EF_RESET  (EF_RESET)
   ) u_ef (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ef_wr_i),
      .wdata_i (ef_wdata_i),
      .ef_o    (ef_val)
   );

   ccs_timeout #(.TW(TW)) u_tmo (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       ((state == ST_VIDEO) && trig),
      .hold_i      (!in_open || ef_hit),
      .act_i       (in_open && rx_valid_i),
      .tick_i      (bit_tick_i),
      .start_lim_i (start_lim_i),
      .end_lim_i   (end_lim_i),
      .start_act_o (start_tmr_o),
      .end_act_o   (end_tmr_o),
      .expire_o    (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_VIDEO;
         drain_cnt    <= 1'b0;
         hs_cnt       <= '0;
         err_seen     <= 1'b0;
         sess_lock    <= 1'b0;
         perm_lock    <= 1'b0;
         err_report_o <= 1'b0;
      end else begin
         err_report_o <= 1'b0;
         unique case (state)
            ST_VIDEO: begin
               if (trig) begin
                  state     <= ST_OPEN;
                  err_seen  <= 1'b0;
                  sess_lock <= 1'b0;
               end
            end
            ST_OPEN: begin
               if (bypass_en_i) begin
                  sess_lock <= 1'b1;
                  if (bypass_perm_i) perm_lock <= 1'b1;
               end
               if (rx_valid_i && rx_err_i) err_seen <= 1'b1;
               if (ef_hit) begin
                  state     <= ST_DRAIN;
                  drain_cnt <= 1'b0;
               end else if (expire) begin
                  state  <= ST_HANDOFF;
                  hs_cnt <= '0;
               end
            end
            ST_DRAIN: begin
               if (bit_tick_i) begin
                  if (drain_cnt) begin
                     state        <= ST_HANDOFF;
                     hs_cnt       <= '0;
                     err_report_o <= err_seen;
                  end else begin
                     drain_cnt <= 1'b1;
                  end
               end
            end
            default: begin
               if (hs_cnt == HS_LAST) state  <= ST_VIDEO;
               else                   hs_cnt <= hs_cnt + 1'b1;
            end
         endcase
      end
   end

   assign chan_en_o   = (state == ST_OPEN) || (state == ST_DRAIN);
   assign video_en_o  = (state == ST_VIDEO);
   assign reg_wr_ok_o = chan_en_o && !sess_lock && !perm_lock;
endmodule

// File: rtl/ccs_session_checker.sv
module ccs_session_checker (
   input logic clk,
   input logic rst_n,
   input logic fsync_i,
   input logic trig_rise_i,
   input logic rx_valid_i,
   input logic bypass_en_i,
   input logic bypass_perm_i,
   input logic chan_en_o,
   input logic video_en_o,
   input logic start_tmr_o,
   input logic end_tmr_o,
   input logic err_report_o,
   input logic reg_wr_ok_o
);
   assert_rise_trig_R1: assert property (@(posedge clk) disable iff (!rst_n)
      video_en_o && trig_rise_i && $rose(fsync_i) |=> chan_en_o);

   assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(chan_en_o && video_en_o));

   assert_open_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_en_o) |-> start_tmr_o && !end_tmr_o);

   assert_timer_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_tmr_o && end_tmr_o));

   assert_act_leaves_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_tmr_o && rx_valid_i |=> !start_tmr_o);

   assert_err_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_report_o |-> $past(chan_en_o && !start_tmr_o && !end_tmr_o) && !chan_en_o);

   assert_video_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_en_o) |-> !video_en_o);

   assert_perm_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en_o && bypass_en_i && bypass_perm_i |=> !reg_wr_ok_o);
endmodule

bind ccs_session_timer ccs_session_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .fsync_i       (fsync_i),
   .trig_rise_i   (trig_rise_i),
   .rx_valid_i    (rx_valid_i),
   .bypass_en_i   (bypass_en_i),
   .bypass_perm_i (bypass_perm_i),
   .chan_en_o     (chan_en_o),
   .video_en_o    (video_en_o),
   .start_tmr_o   (start_tmr_o),
   .end_tmr_o     (end_tmr_o),
   .err_report_o  (err_report_o),
   .reg_wr_ok_o   (reg_wr_ok_o)
);

// File: tb/ccs_session_timer_tb.sv
module ccs_session_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync_i = 1'b0;
   logic        trig_rise_i = 1'b1;
   logic        bit_tick_i = 1'b0;
   logic        rx_valid_i = 1'b0;
   logic [7:0]  rx_data_i = 8'h00;
   logic        rx_err_i = 1'b0;
   logic [15:0] start_lim_i = 16'd10;
   logic [15:0] end_lim_i = 16'd6;
   logic        ef_wr_i = 1'b0;
   logic [7:0]  ef_wdata_i = 8'h00;
   logic        bypass_en_i = 1'b0;
   logic        bypass_perm_i = 1'b0;
   logic        chan_en_o, video_en_o, start_tmr_o, end_tmr_o, err_report_o, reg_wr_ok_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ccs_session_timer u_dut (
      .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .trig_rise_i(trig_rise_i),
      .bit_tick_i(bit_tick_i), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
      .rx_err_i(rx_err_i), .start_lim_i(start_lim_i), .end_lim_i(end_lim_i),
      .ef_wr_i(ef_wr_i), .ef_wdata_i(ef_wdata_i), .bypass_en_i(bypass_en_i),
      .bypass_perm_i(bypass_perm_i), .chan_en_o(chan_en_o), .video_en_o(video_en_o),
      .start_tmr_o(start_tmr_o), .end_tmr_o(end_tmr_o), .err_report_o(err_report_o),
      .reg_wr_ok_o(reg_wr_ok_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Behavioural reference: 0 video, 1 open, 2 draining, 3 handing back
   int   m_st = 0, m_ph = 0, m_cnt = 0, m_dr = 0, m_hs = 0;
   int   m_ef = 255;
   bit   m_pfs = 0, m_err = 0, m_slock = 0, m_plock = 0, m_errp = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_ph = 0; m_cnt = 0; m_dr = 0; m_hs = 0; m_ef = 255;
         m_pfs = 0; m_err = 0; m_slock = 0; m_plock = 0; m_errp = 0;
      end else begin
         bit trg;
         int lim;
         trg = trig_rise_i ? (fsync_i && !m_pfs) : (!fsync_i && m_pfs);
         m_pfs = fsync_i;
         m_errp = 0;
         if (m_st == 0) begin
            if (trg) begin
               m_st = 1; m_ph = 1; m_cnt = 0; m_err = 0; m_slock = 0;
            end
         end else if (m_st == 1) begin
            if (bypass_en_i) begin
               m_slock = 1;
               if (bypass_perm_i) m_plock = 1;
            end
            if (rx_valid_i && rx_err_i) m_err = 1;
            if (rx_valid_i && int'(rx_data_i) == m_ef) begin
               m_st = 2; m_dr = 0; m_ph = 0; m_cnt = 0;
            end else if (rx_valid_i) begin
               m_ph = 2; m_cnt = 0;
            end else if (bit_tick_i) begin
               lim = (m_ph == 1) ? int'(start_lim_i) : int'(end_lim_i);
               if (lim < 1) lim = 1;
               if (m_cnt + 1 >= lim) begin
                  m_st = 3; m_hs = 0; m_ph = 0; m_cnt = 0;
               end else m_cnt++;
            end
         end else if (m_st == 2) begin
            if (bit_tick_i) begin
               if (m_dr == 1) begin
                  m_st = 3; m_hs = 0; m_errp = m_err;
               end else m_dr = 1;
            end
         end else begin
            if (m_hs == 7) m_st = 0;
            else m_hs++;
         end
         if (ef_wr_i && ef_wdata_i != 8'h80 && ef_wdata_i != 8'h90) m_ef = int'(ef_wdata_i);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 chan_en", chan_en_o, (m_st == 1 || m_st == 2));
         check("R10 video_en", video_en_o, (m_st == 0));
         check("R3 start_tmr", start_tmr_o, (m_ph == 1));
         check("R5 end_tmr", end_tmr_o, (m_ph == 2));
         check("R9 err_report", err_report_o, m_errp);
         check("R11 reg_wr_ok", reg_wr_ok_o, (m_st == 1 || m_st == 2) && !m_slock && !m_plock);
      end
   end

   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div = (div + 1) % 4;
         bit_tick_i = (div == 0);
      end
   end

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
         end
      end
   end

   task automatic fs_set(input logic v);
      fsync_i = v;
      @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] d, input logic e);
      rx_valid_i = 1'b1; rx_data_i = d; rx_err_i = e;
      @(negedge clk);
      rx_valid_i = 1'b0; rx_err_i = 1'b0;
   endtask

   task automatic ef_write(input logic [7:0] d);
      ef_wr_i = 1'b1; ef_wdata_i = d;
      @(negedge clk);
      ef_wr_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // waits for video_en; returns open cycles and whether err_report fired
   task automatic wait_video(output int cycles, output bit saw_err);
      cycles = 0; saw_err = 0;
      for (int i = 0; i < 600; i++) begin
         if (video_en_o) break;
         if (err_report_o) saw_err = 1;
         if (chan_en_o) cycles++;
         @(negedge clk);
      end
   endtask

   initial begin
      int  cy;
      bit  se;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 video_en", video_en_o, 1'b1);
      check("R12 chan_en", chan_en_o, 1'b0);
      check("R12 timers", start_tmr_o | end_tmr_o, 1'b0);
      check("R12 err/ok", err_report_o | reg_wr_ok_o, 1'b0);

      // R1 rising trigger, then start timeout (R3, R6)
      fs_set(1'b1);
      check("R1 chan after rising", chan_en_o, 1'b1);
      check("R1 video off", video_en_o, 1'b0);
      check("R3 start armed", start_tmr_o, 1'b1);
      // R2 edges while open ignored
      fs_set(1'b0); fs_set(1'b1);
      check("R2 still start", start_tmr_o, 1'b1);
      fs_set(1'b0);
      wait_video(cy, se);
      check("R6 start timeout closed", (cy >= 36 && cy <= 41), 1'b1);

      // R5 activity hands over to end timer, restarts it
      fs_set(1'b1);
      send_byte(8'h11, 1'b0);
      check("R5 end active", end_tmr_o, 1'b1);
      check("R4 start off", start_tmr_o, 1'b0);
      idle(14);
      send_byte(8'h12, 1'b0);
      check("R5 restart keeps open", chan_en_o, 1'b1);
      idle(14);
      check("R5 still open", chan_en_o, 1'b1);
      fs_set(1'b0);
      wait_video(cy, se);
      check("R9 no report on timeout", se, 1'b0);

      // R7/R9 end frame close with error
      fs_set(1'b1);
      send_byte(8'h22, 1'b1);
      send_byte(8'hFF, 1'b0);
      check("R7 open right after EF", chan_en_o, 1'b1);
      check("R7 timers stopped", start_tmr_o | end_tmr_o, 1'b0);
      wait_video(cy, se);
      check("R9 report on EF close", se, 1'b1);
      check("R7 drain length", (cy >= 4 && cy <= 9), 1'b1);
      fs_set(1'b0);

      // R9 error but timeout close
      fs_set(1'b1);
      send_byte(8'h33, 1'b1);
      wait_video(cy, se);
      check("R9 timeout hides error", se, 1'b0);
      fs_set(1'b0);

      // R8 end-frame programming
      ef_write(8'hA5);
      ef_write(8'h80);
      ef_write(8'h90);
      fs_set(1'b1);
      send_byte(8'hFF, 1'b0);
      idle(10);
      check("R8 0xFF no longer closes", chan_en_o, 1'b1);
      send_byte(8'h80, 1'b0);
      idle(10);
      check("R8 address not taken as EF", chan_en_o, 1'b1);
      send_byte(8'hA5, 1'b0);
      wait_video(cy, se);
      check("R8 kept value closes", (cy <= 9), 1'b1);
      fs_set(1'b0);
      ef_write(8'hFF);

      // R1 falling trigger
      fsync_i = 1'b1;
      trig_rise_i = 1'b0;
      @(negedge clk);
      fs_set(1'b1);
      check("R1 no trigger w/o edge", video_en_o, 1'b1);
      fs_set(1'b0);
      check("R1 falling triggers", chan_en_o, 1'b1);
      wait_video(cy, se);
      trig_rise_i = 1'b1;
      @(negedge clk);

      // R11 bypass for one session
      fs_set(1'b1);
      check("R11 ok when open", reg_wr_ok_o, 1'b1);
      bypass_en_i = 1'b1;
      @(negedge clk);
      bypass_en_i = 1'b0;
      check("R11 session block", reg_wr_ok_o, 1'b0);
      fs_set(1'b0);
      wait_video(cy, se);
      fs_set(1'b1);
      check("R11 block cleared next session", reg_wr_ok_o, 1'b1);
      bypass_en_i = 1'b1; bypass_perm_i = 1'b1;
      @(negedge clk);
      bypass_en_i = 1'b0; bypass_perm_i = 1'b0;
      fs_set(1'b0);
      wait_video(cy, se);
      fs_set(1'b1);
      check("R11 permanent block", reg_wr_ok_o, 1'b0);
      fs_set(1'b0);
      wait_video(cy, se);

      // R4 small limits
      start_lim_i = 16'd1;
      fs_set(1'b1);
      wait_video(cy, se);
      check("R4 limit 1", (cy <= 5), 1'b1);
      fs_set(1'b0);
      start_lim_i = 16'd0;
      fs_set(1'b1);
      wait_video(cy, se);
      check("R4 limit 0 as 1", (cy <= 5), 1'b1);
      fs_set(1'b0);
      start_lim_i = 16'd3;
      end_lim_i = 16'd2;
      fs_set(1'b1);
      send_byte(8'h44, 1'b0);
      wait_video(cy, se);
      check("R4 end limit 2", (cy >= 5 && cy <= 10), 1'b1);
      idle(5);
      finish_run();
   end
endmodule